// File: doc/BRIEF.md
# Buffer control word write sequencer

This block sits on the controller side of a DDR4 load-reduced memory channel. It turns one control word request into the ordered writes a data buffer needs. A request names a function space, a word number, a data value and whether the word is a 4-bit or an 8-bit word. The buffer reaches its words through a paged space pointer, so the sequencer first writes the space selector and then writes the target word. It keeps the required idle gap after every write. The gap depends on which word was written.

Requests arrive over a valid/ready handshake and are taken one at a time. A request may mark itself as the last of a batch. If the last request of a batch ran in a non-zero space, the sequencer writes the pointer back to space 0, so the next batch starts from a known page. Requests that break the legality rules are refused: an error pulse is raised and no write is issued. The writes leave the block as an abstract strobe with space, word, data and width fields. The encoding onto the DRAM command bus is not part of this block.

Top module: `bcw_seq`

## Requirements
- R1: `req_ready` is high exactly when `busy` is low, and a request is taken on a rising edge where `req_valid` and `req_ready` are both high. After reset, `busy` is low, no strobe is issued and `cur_space` is 0.
- R2: A request is refused in four cases: its space is 8 or more; it is a 4-bit word (`req_wide`=0) outside space 0; it is a 4-bit word whose data has any of bits 7:4 set; it is a 4-bit word numbered 7. For a refused request, `err` is high for the one cycle after the accepting edge, no strobe is issued, `busy` stays low and `cur_space` keeps its value.
- R3: The first strobe of an accepted request comes in the cycle after the accepting edge. It is a selector write: space 0, word 7, `wr_wide`=0, and data equal to the requested space.
- R4: The target strobe comes exactly T_MRD cycles after the selector strobe. It carries the requested space, word, data and width flag. No strobe is issued between the two.
- R5: After the target write of an ordinary word, the wait is T_MRC cycles (16 by default). If no return write follows, `done` comes T_MRC cycles after the target strobe.
- R6: A 4-bit write to word 0xA waits T_DLLK cycles instead of T_MRC.
- R7: When the request is marked last and its space is non-zero, a return write (space 0, word 7, data 0) comes one target wait after the target strobe. `done` follows T_MRD cycles after that. A request that is not marked last leaves the pointer on its space.
- R8: `done` is high for exactly one cycle, at the end of the final wait. `busy` is high from the cycle after acceptance up to and including that cycle.
- R9: `cur_space` takes the data of each selector write in the cycle after its strobe.
- R10: An 8-bit write to word 0xA, in any space, uses the ordinary T_MRC wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_space | input | SP_W+1 (4) | Requested function space (extra bit lets illegal values be expressed) |
| req_word | input | WORD_W (4) | Control word number |
| req_data | input | DATA_W (8) | Control word data |
| req_wide | input | 1 | 1 for an 8-bit word, 0 for a 4-bit word |
| req_last | input | 1 | Last request of a batch |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_space | output | SP_W (3) | Space field of the write |
| wr_word | output | WORD_W (4) | Word field of the write |
| wr_data | output | DATA_W (8) | Data field of the write |
| wr_wide | output | 1 | Width flag of the write |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when a request completes |
| err | output | 1 | One-cycle pulse for a refused request |
| cur_space | output | SP_W (3) | Tracked function space pointer |

## Verification
The hardest case to reach from the ports is a refused request that arrives while the pointer is parked on a non-zero space. The test must show that the refusal leaves that pointer alone. To get there, the stimulus sends an 8-bit request that is not marked last, which leaves the pointer at 6. It then sends several illegal requests, one for each refusal rule, before the next legal batch. The long T_DLLK wait, and the two flavours of word 0xA, are reached by pairing a 4-bit and an 8-bit request to that word number.

// File: rtl/bcw_seq.sv
module bcw_seq #(
  parameter int T_MRD      = 8,
  parameter int T_MRC      = 16,
  parameter int T_DLLK     = 512,
  parameter int SPACES     = 8,
  parameter int WORD_W     = 4,
  parameter int DATA_W     = 8,
  parameter int NARROW_W   = 4,
  parameter int SEL_WORD   = 7,
  parameter int SPEED_WORD = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [$clog2(SPACES):0]    req_space,
  input  logic [WORD_W-1:0]          req_word,
  input  logic [DATA_W-1:0]          req_data,
  input  logic                       req_wide,
  input  logic                       req_last,
  output logic                       wr_stb,
  output logic [$clog2(SPACES)-1:0]  wr_space,
  output logic [WORD_W-1:0]          wr_word,
  output logic [DATA_W-1:0]          wr_data,
  output logic                       wr_wide,
  output logic                       busy,
  output logic                       done,
  output logic                       err,
  output logic [$clog2(SPACES)-1:0]  cur_space
);
  localparam int SP_W  = $clog2(SPACES);
  localparam int MAXW  = (T_DLLK > T_MRC) ? ((T_DLLK > T_MRD) ? T_DLLK : T_MRD)
                                          : ((T_MRC > T_MRD) ? T_MRC : T_MRD);
  localparam int CNT_W = $clog2(MAXW + 1);

  typedef enum logic [2:0] {IDLE, SEL, TGT, RET, FIN} phase_t;

  phase_t              ph;
  logic [CNT_W-1:0]    cnt;
  logic [SP_W-1:0]     r_space;
  logic [WORD_W-1:0]   r_word;
  logic [DATA_W-1:0]   r_data;
  logic                r_wide, r_last;
  logic                legal, accept, issue, zero;
  logic [CNT_W-1:0]    tgt_wait;

  assign legal = (int'(req_space) < SPACES) &&
                 (req_wide || (req_space == '0 &&
                               req_data[DATA_W-1:NARROW_W] == '0 &&
                               int'(req_word) != SEL_WORD));
  assign req_ready = (ph == IDLE);
  assign busy      = (ph != IDLE);
  assign accept    = req_valid && req_ready;
  assign zero      = (cnt == '0);
  assign issue     = zero && (ph == SEL || ph == TGT || ph == RET);
  assign done      = zero && (ph == FIN);
  assign wr_stb    = issue;
  assign tgt_wait  = (!r_wide && int'(r_word) == SPEED_WORD) ? CNT_W'(T_DLLK - 1)
                                                            : CNT_W'(T_MRC - 1);

  always_comb begin
    wr_space = '0;
    wr_word  = '0;
    wr_data  = '0;
    wr_wide  = 1'b0;
    if (issue) begin
      case (ph)
        SEL: begin
          wr_word = WORD_W'(SEL_WORD);
          wr_data = DATA_W'(r_space);
        end
        TGT: begin
          wr_space = r_space;
          wr_word  = r_word;
          wr_data  = r_data;
          wr_wide  = r_wide;
        end
        default: wr_word = WORD_W'(SEL_WORD);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= IDLE;
      cnt       <= '0;
      err       <= 1'b0;
      cur_space <= '0;
      r_space   <= '0;
      r_word    <= '0;
      r_data    <= '0;
      r_wide    <= 1'b0;
      r_last    <= 1'b0;
    end else begin
      err <= 1'b0;
      case (ph)
        IDLE: if (accept) begin
          if (legal) begin
            r_space <= req_space[SP_W-1:0];
            r_word  <= req_word;
            r_data  <= req_data;
            r_wide  <= req_wide;
            r_last  <= req_last;
            cnt     <= '0;
            ph      <= SEL;
          end else begin
            err <= 1'b1;
          end
        end
        SEL: if (zero) begin
          cur_space <= r_space;
          cnt       <= CNT_W'(T_MRD - 1);
          ph        <= TGT;
        end else cnt <= cnt - 1'b1;
        TGT: if (zero) begin
          cnt <= tgt_wait;
          ph  <= (r_last && r_space != '0) ? RET : FIN;
        end else cnt <= cnt - 1'b1;
        RET: if (zero) begin
          cur_space <= '0;
          cnt       <= CNT_W'(T_MRD - 1);
          ph        <= FIN;
        end else cnt <= cnt - 1'b1;
        default: if (zero) ph <= IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/bcw_seq_chk.sv
module bcw_seq_chk #(
  parameter int SP_W     = 3,
  parameter int WORD_W   = 4,
  parameter int DATA_W   = 8,
  parameter int SEL_WORD = 7,
  parameter int T_MRD    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              wr_stb,
  input logic [SP_W-1:0]   wr_space,
  input logic [WORD_W-1:0] wr_word,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_wide,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [SP_W-1:0]   cur_space
);
  logic [15:0] gap;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (wr_stb) begin
      gap  <= 16'd1;
      seen <= 1'b1;
    end else if (gap != 16'hFFFF) begin
      gap <= gap + 16'd1;
    end
  end

  AST_SEL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wr_stb && int'(wr_word) == SEL_WORD && wr_space == '0 && !wr_wide); // R3
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy && !wr_stb); // R2
  AST_PTR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && int'(wr_word) == SEL_WORD && !wr_wide && wr_space == '0)
      |=> cur_space == $past(wr_data[SP_W-1:0])); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R8
  AST_STB_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> busy && !req_ready); // R1
  AST_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && seen) |-> int'(gap) >= T_MRD); // R4
endmodule

bind bcw_seq bcw_seq_chk #(
  .SP_W(SP_W), .WORD_W(WORD_W), .DATA_W(DATA_W), .SEL_WORD(SEL_WORD), .T_MRD(T_MRD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .wr_stb(wr_stb),
  .wr_space(wr_space), .wr_word(wr_word), .wr_data(wr_data), .wr_wide(wr_wide),
  .busy(busy), .done(done), .err(err), .cur_space(cur_space)
);

// File: tb/bcw_seq_bench.sv
module bcw_seq_bench;
  localparam int T_MRD = 8, T_MRC = 16, T_DLLK = 512;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_ready;
  logic [3:0] req_space = '0, req_word = '0;
  logic [7:0] req_data = '0;
  logic       req_wide = 1'b0, req_last = 1'b0;
  logic       wr_stb, wr_wide, busy, done, err;
  logic [2:0] wr_space, cur_space;
  logic [3:0] wr_word;
  logic [7:0] wr_data;

  bcw_seq #(.T_MRD(T_MRD), .T_MRC(T_MRC), .T_DLLK(T_DLLK)) u_bcw_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_space(req_space), .req_word(req_word), .req_data(req_data),
    .req_wide(req_wide), .req_last(req_last), .wr_stb(wr_stb),
    .wr_space(wr_space), .wr_word(wr_word), .wr_data(wr_data), .wr_wide(wr_wide),
    .busy(busy), .done(done), .err(err), .cur_space(cur_space));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  int q_cyc[$], q_sp[$], q_wd[$], q_dt[$], q_wide[$];
  string q_tag[$];
  int busy_lo = -1, busy_hi = -2, done_cyc = -1, err_cyc = -1;
  int mptr = 0, upd_cyc = -1, upd_val = 0;
  string done_tag = "R5";
  bit finished = 1'b0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic schedule(int a, int sp, int wd, int dt, int wide, int last);
    int t, w;
    bit ok;
    ok = (sp < 8) && (wide != 0 || (sp == 0 && dt < 16 && wd != 7));
    if (!ok) begin
      err_cyc = a;
      return;
    end
    q_cyc.push_back(a); q_sp.push_back(0); q_wd.push_back(7);
    q_dt.push_back(sp); q_wide.push_back(0); q_tag.push_back("R3");
    q_cyc.push_back(a + T_MRD); q_sp.push_back(sp); q_wd.push_back(wd);
    q_dt.push_back(dt); q_wide.push_back(wide); q_tag.push_back("R4");
    w = (wide == 0 && wd == 10) ? T_DLLK : T_MRC;
    done_tag = (wide == 0 && wd == 10) ? "R6" : (wd == 10) ? "R10" : "R5";
    t = a + T_MRD + w;
    if (last != 0 && sp != 0) begin
      q_cyc.push_back(t); q_sp.push_back(0); q_wd.push_back(7);
      q_dt.push_back(0); q_wide.push_back(0); q_tag.push_back("R7");
      t += T_MRD;
      done_tag = "R7";
    end
    done_cyc = t;
    busy_lo  = a;
    busy_hi  = t;
  endtask

  always @(negedge clk) if (!finished) begin
    bit exp_stb;
    if (cyc == upd_cyc) mptr = upd_val;
    exp_stb = (q_cyc.size() > 0) && (q_cyc[0] == cyc);
    if (exp_stb) begin
      chk(q_tag[0], int'(wr_stb), 1);
      chk(q_tag[0], int'(wr_space), q_sp[0]);
      chk(q_tag[0], int'(wr_word), q_wd[0]);
      chk(q_tag[0], int'(wr_data), q_dt[0]);
      chk(q_tag[0], int'(wr_wide), q_wide[0]);
      if (q_tag[0] != "R4") begin
        upd_cyc = cyc + 1;
        upd_val = q_dt[0];
      end
      void'(q_cyc.pop_front()); void'(q_sp.pop_front()); void'(q_wd.pop_front());
      void'(q_dt.pop_front()); void'(q_wide.pop_front()); void'(q_tag.pop_front());
    end else begin
      chk("R4", int'(wr_stb), 0);
    end
    chk("R1", int'(req_ready), (cyc >= busy_lo && cyc <= busy_hi) ? 0 : 1);
    chk((cyc == done_cyc) ? done_tag : "R8", int'(done), (cyc == done_cyc) ? 1 : 0);
    chk("R2", int'(err), (cyc == err_cyc) ? 1 : 0);
    chk("R9", int'(cur_space), mptr);
    if (rst_n && req_valid && req_ready)
      schedule(cyc + 1, int'(req_space), int'(req_word), int'(req_data),
               int'(req_wide), int'(req_last));
  end

  task automatic send(int sp, int wd, int dt, bit wide, bit last);
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_space = 4'(sp);
    req_word  = 4'(wd);
    req_data  = 8'(dt);
    req_wide  = wide;
    req_last  = last;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) if (!finished && cyc > 100000) begin
    total++;
    bad++;
    $display("FAIL watchdog cyc=%0d actual=running expected=finished", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    send(0, 3, 5, 1'b0, 1'b1);       // R5 plain 4-bit word
    send(0, 10, 2, 1'b0, 1'b1);      // R6 speed word
    send(6, 4, 'hA5, 1'b1, 1'b0);    // R4 8-bit, pointer parked at 6
    send(9, 1, 1, 1'b1, 1'b1);       // R2 space out of range
    send(2, 1, 1, 1'b0, 1'b1);       // R2 4-bit outside space 0
    send(0, 1, 'h1F, 1'b0, 1'b1);    // R2 4-bit data too wide
    send(0, 7, 3, 1'b0, 1'b1);       // R2 selector word targeted
    send(5, 6, 'h3C, 1'b1, 1'b1);    // R7 return to space 0
    send(3, 10, 'h11, 1'b1, 1'b1);   // R10 8-bit word 0xA
    send(7, 2, 'hFF, 1'b1, 1'b1);    // R7 highest space
    send(0, 4, 'hF, 1'b0, 1'b0);     // R5 space 0, no return
    repeat (600) @(negedge clk);
    finish_run();
  end
endmodule